// File: doc/BRIEF.md
# Pipelined Converter Digit Alignment and Correction

This block sits behind the analog stages of a pipelined analog-to-digital converter. Every stage produces a small signed digit for the sample it holds. Stage s reports its digit s clock cycles after the first stage, because each stage works on the residue that the stage in front of it passed along. The block delays the early digits until every digit of one sample is present in the same cycle. It then adds the digits at weights that overlap by one bit and adds a fixed offset, which gives an unsigned 12-bit code. The overlap is the reason comparator thresholds in the redundant stages may be off by a sizeable fraction of the reference without changing the final result by more than one code.

The parameter `LAYOUT` selects one of two stage chains. With `LAYOUT = 0` the chain has ten 1.5-bit stages and a 2-bit flash. With `LAYOUT = 1` the chain has one 2.5-bit front stage, seven 1.5-bit stages and a 3-bit flash. Both chains use the same port list, and each chain ignores the input bits it has no use for. A strobe marks the cycle in which the first stage presents a new sample. A valid flag comes out together with the corrected code. A sticky error flag reports any forbidden stage code that was part of a sample.

Top module: `pipe_digit_corrector`

## Requirements
- R1: With LAYOUT 0, stage j (j = 0..9) drives `mid_codes[2j+1:2j]`. Its code maps 00 to -1, 01 to 0 and 10 to +1. The flash value f is `flash_code[1:0]`. The output is 2046 + sum of d_j * 2^(10-j) + f.
- R2: With LAYOUT 1, stage 0 drives `front_code`. Its value c (0..6) gives the digit c-3, weighted by 512. Stage j+1 (j = 0..6) drives `mid_codes[2j+1:2j]` and is weighted by 2^(8-j), with the same digit map as in R1. The flash value f is `flash_code` (0..7). The output is 2044 + 512*(c-3) + sum of d_j * 2^(8-j) + f.
- R3: For a sample strobed in cycle t, the code of stage s is taken from its port in cycle t+s. The last stage is the flash, which is stage 10 with LAYOUT 0 and stage 8 with LAYOUT 1.
- R4: `out_valid` is high in cycle t+N for a sample strobed in cycle t, where N is the number of stages (11 with LAYOUT 0, 9 with LAYOUT 1). The new code appears in that same cycle. A strobe in every cycle yields one result in every cycle.
- R5: While `out_valid` is low, `out_code` keeps the value of the last result.
- R6: All-minimum legal digits give code 0 and all-maximum legal digits give code 4095, in both layouts.
- R7: The result stays within one code of the ideal value (Vin+Vref)*2048/Vref, limited to 4095, when each 1.5-bit comparator threshold is displaced by up to Vref/8 and each front comparator threshold by up to Vref/16.
- R8: A 1.5-bit code of 11 or a front code of 111 within a strobed sample counts as digit zero. It sets `code_error` in the cycle that sample's `out_valid` goes high, and `code_error` stays set until reset.
- R9: Forbidden codes on stage inputs in cycles that belong to no strobed sample leave `code_error` unchanged.
- R10: With LAYOUT 0, `front_code` and `flash_code[2]` have no effect. With LAYOUT 1, `mid_codes[19:14]` has no effect.
- R11: Reset (active low, asynchronous) clears `out_code`, `out_valid` and `code_error` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_strobe | input | 1 | First-stage code of a new sample is present |
| front_code | input | 3 | 2.5-bit front stage code (LAYOUT 1 only) |
| mid_codes | input | 20 | Packed 2-bit codes of the 1.5-bit stages |
| flash_code | input | 3 | Flash stage value |
| out_code | output | 12 | Corrected converter code |
| out_valid | output | 1 | `out_code` holds a new result this cycle |
| code_error | output | 1 | Sticky: a forbidden code was seen in a sample |

## Verification
The bench builds two instances, one with LAYOUT 0 and one with LAYOUT 1. Between them they cover both delay depths, both offset constants, the weighted front digit and both flash widths. A behavioural model of the analog chain, with comparator thresholds deliberately displaced, generates stage codes for chosen input voltages. This puts the redundancy claim within reach in both layouts. Directed digit patterns test each stage weight by itself, both end points of the range, strobes that arrive back to back or with gaps, and junk driven on the bits each layout ignores.

// File: rtl/pipe_digit_corrector.sv
module pipe_digit_corrector #(
  parameter int LAYOUT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_strobe,
  input  logic [2:0]  front_code,
  input  logic [19:0] mid_codes,
  input  logic [2:0]  flash_code,
  output logic [11:0] out_code,
  output logic        out_valid,
  output logic        code_error
);
  localparam int NMID    = (LAYOUT != 0) ? 7 : 10;
  localparam int MOFF    = (LAYOUT != 0) ? 1 : 0;
  localparam int LAST    = NMID + MOFF;
  localparam int FW      = (LAYOUT != 0) ? 3 : 2;
  localparam int W0      = (LAYOUT != 0) ? 256 : 1024;
  localparam int OFFS    = (LAYOUT != 0) ? 2044 : 2046;
  localparam int FRONT_W = 512;
  localparam int SW      = 14;

  logic [1:0]          mid_al [NMID];
  logic [2:0]          front_al;
  logic [LAST-1:0]     vpipe;
  logic                aligned;
  logic signed [SW-1:0] acc;
  logic                bad;
  logic                unused_bits;

  assign unused_bits = ^{front_code, flash_code, mid_codes};
  assign aligned = vpipe[LAST-1];

  genvar j;
  generate
    for (j = 0; j < NMID; j++) begin : g_mid
      localparam int DEP = LAST - j - MOFF;
      logic [1:0] dl [DEP];
      always_ff @(posedge clk) begin
        dl[0] <= mid_codes[2*j +: 2];
        for (int k = 1; k < DEP; k++) dl[k] <= dl[k-1];
      end
      assign mid_al[j] = dl[DEP-1];
    end
    if (MOFF != 0) begin : g_front
      logic [2:0] fdl [LAST];
      always_ff @(posedge clk) begin
        fdl[0] <= front_code;
        for (int k = 1; k < LAST; k++) fdl[k] <= fdl[k-1];
      end
      assign front_al = fdl[LAST-1];
    end else begin : g_nofront
      assign front_al = 3'd3;
    end
  endgenerate

  always_comb begin
    acc = SW'(OFFS);
    bad = 1'b0;
    for (int m = 0; m < NMID; m++) begin
      case (mid_al[m])
        2'b00:   acc = acc - SW'(W0 >> m);
        2'b10:   acc = acc + SW'(W0 >> m);
        2'b11:   bad = 1'b1;
        default: ;
      endcase
    end
    if (MOFF != 0) begin
      if (front_al == 3'b111) bad = 1'b1;
      else acc = acc + SW'(FRONT_W * (int'(front_al) - 3));
    end
    acc = acc + SW'(flash_code[FW-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpipe      <= '0;
      out_valid  <= 1'b0;
      out_code   <= '0;
      code_error <= 1'b0;
    end else begin
      vpipe     <= {vpipe[LAST-2:0], smp_strobe};
      out_valid <= aligned;
      if (aligned) begin
        out_code <= acc[11:0];
        if (bad) code_error <= 1'b1;
      end
    end
  end

  logic [4:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (since != 5'(LAST + 2)) since <= since + 5'd1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 5'(LAST + 2)) |-> (out_valid == $past(smp_strobe, LAST + 1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_code) |-> out_valid);

  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |-> (acc >= 0 && acc <= 4095));

  assert_error_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    code_error |=> code_error);

  assert_error_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_error) |-> out_valid);
endmodule

// File: tb/test_pipe_digit_corrector.sv
module test_pipe_digit_corrector;
  localparam int VR = 1 << 20;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #5 clk = ~clk;

  logic        stb [2];
  logic [2:0]  fr  [2];
  logic [19:0] md  [2];
  logic [2:0]  fl  [2];
  logic [11:0] oc  [2];
  logic        ov  [2];
  logic        oe  [2];

  pipe_digit_corrector #(.LAYOUT(0)) i_pipe_digit_corrector (
    .clk(clk), .rst_n(rst_n), .smp_strobe(stb[0]), .front_code(fr[0]),
    .mid_codes(md[0]), .flash_code(fl[0]), .out_code(oc[0]),
    .out_valid(ov[0]), .code_error(oe[0]));

  pipe_digit_corrector #(.LAYOUT(1)) i_pipe_digit_corrector_b (
    .clk(clk), .rst_n(rst_n), .smp_strobe(stb[1]), .front_code(fr[1]),
    .mid_codes(md[1]), .flash_code(fl[1]), .out_code(oc[1]),
    .out_valid(ov[1]), .code_error(oe[1]));

  bit         lv [2][64];
  logic [2:0] cd [2][64][11];
  int         ex [2][64];
  bit         tl [2][64];
  string      rq [2][64];
  int q = 0;
  int nchk = 0;
  int nfail = 0;
  int last_code [2];
  bit ill_fill = 0;
  int junk_mode = 0;

  function automatic int last_of(int x);
    return (x != 0) ? 8 : 10;
  endfunction

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int dig(logic [2:0] c);
    case (c[1:0])
      2'b00:   return -1;
      2'b10:   return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int expect_code(int x, int s);
    int v;
    if (x == 0) begin
      v = 2046 + int'(cd[x][s][10][1:0]);
      for (int j = 0; j < 10; j++) v += dig(cd[x][s][j]) * (1 << (10 - j));
    end else begin
      v = 2044 + int'(cd[x][s][8]);
      if (cd[x][s][0] != 3'b111) v += 512 * (int'(cd[x][s][0]) - 3);
      for (int j = 0; j < 7; j++) v += dig(cd[x][s][j+1]) * (1 << (8 - j));
    end
    return v;
  endfunction

  function automatic logic [32:0] model(int x, int vin);
    logic [32:0] pk;
    longint v, th, hi, lo;
    int cnt, s0, nm, fb, d;
    pk = '0;
    v = vin;
    s0 = 0;
    if (x != 0) begin
      cnt = 0;
      for (int k = 0; k < 6; k++) begin
        th = longint'(((2*k - 5) * VR) / 8) + longint'(((k % 3) - 1) * (VR / 16));
        if (v > th) cnt++;
      end
      pk[2:0] = 3'(cnt);
      v = 4*v - longint'(cnt - 3) * VR;
      s0 = 1;
    end
    nm = (x != 0) ? 7 : 10;
    for (int j = 0; j < nm; j++) begin
      hi = longint'(VR / 4) + longint'((((j*5) % 5 + j % 5) % 5 - 2) * (VR / 16));
      lo = -longint'(VR / 4) + longint'((((j*3 + 3) % 5) - 2) * (VR / 16));
      d = (v > hi) ? 1 : ((v < lo) ? -1 : 0);
      pk[3*(j+s0) +: 3] = (d == 1) ? 3'd2 : ((d == 0) ? 3'd1 : 3'd0);
      v = 2*v - longint'(d) * VR;
    end
    fb = (x != 0) ? 7 : 3;
    cnt = 0;
    for (int k = 1; k <= fb; k++) begin
      th = longint'(((2*k - fb - 1) * VR) / (fb + 1));
      if (v > th) cnt++;
    end
    pk[3*(nm+s0) +: 3] = 3'(cnt);
    return pk;
  endfunction

  function automatic int ideal(int vin);
    longint e;
    e = ((longint'(vin) + VR) * 2048) / VR;
    if (e > 4095) e = 4095;
    return int'(e);
  endfunction

  function automatic logic [32:0] zero_pk(int x);
    logic [32:0] pk;
    pk = '0;
    for (int s = 0; s < last_of(x); s++) pk[3*s +: 3] = 3'd1;
    if (x != 0) pk[2:0] = 3'd3;
    return pk;
  endfunction

  function automatic logic [32:0] rand_pk(int x);
    logic [32:0] pk;
    pk = '0;
    for (int s = 0; s < last_of(x); s++) pk[3*s +: 3] = 3'($urandom % 3);
    if (x != 0) pk[2:0] = 3'($urandom % 7);
    pk[3*last_of(x) +: 3] = 3'($urandom % ((x != 0) ? 8 : 4));
    return pk;
  endfunction

  task automatic launch(int x, int slot, logic [32:0] pk, int force_exp, bit tol, string r);
    for (int s = 0; s < 11; s++) cd[x][slot & 63][s] = pk[3*s +: 3];
    lv[x][slot & 63] = 1'b1;
    tl[x][slot & 63] = tol;
    rq[x][slot & 63] = r;
    ex[x][slot & 63] = (force_exp >= 0) ? force_exp : expect_code(x, slot & 63);
  endtask

  function automatic logic [2:0] filler(int x, int s);
    if (s == last_of(x)) return 3'd0;
    if (x != 0 && s == 0) return ill_fill ? 3'b111 : 3'd3;
    return ill_fill ? 3'b011 : 3'b001;
  endfunction

  function automatic logic [19:0] junk();
    if (junk_mode == 1) return '1;
    if (junk_mode == 2) return '0;
    return 20'($urandom);
  endfunction

  task automatic step();
    @(negedge clk);
    for (int x = 0; x < 2; x++) begin
      int c;
      bit ev;
      int dlt;
      c = q - 1 - last_of(x);
      ev = (c >= 0) ? lv[x][c & 63] : 1'b0;
      if (ev || ov[x]) begin
        chk(ev ? rq[x][c & 63] : "R4 spurious valid", int'(ov[x]), int'(ev));
        if (ev) begin
          if (tl[x][c & 63]) begin
            nchk++;
            dlt = int'(oc[x]) - ex[x][c & 63];
            if (dlt < -1 || dlt > 1) begin
              nfail++;
              $display("FAIL %s: actual %0d expected %0d (+-1)", rq[x][c & 63],
                       oc[x], ex[x][c & 63]);
            end
          end else begin
            chk(rq[x][c & 63], int'(oc[x]), ex[x][c & 63]);
          end
          last_code[x] = int'(oc[x]);
        end
      end else begin
        chk("R5 hold", int'(oc[x]), last_code[x]);
      end
      if (c >= 0) lv[x][c & 63] = 1'b0;
    end
    for (int x = 0; x < 2; x++) begin
      logic [19:0] jk;
      jk = junk();
      stb[x] = lv[x][q & 63];
      fr[x] = jk[2:0];
      fl[x] = jk[5:3];
      md[x] = jk;
      for (int s = 0; s <= last_of(x); s++) begin
        int p;
        logic [2:0] cv;
        p = q - s;
        cv = (p >= 0 && lv[x][p & 63]) ? cd[x][p & 63][s] : filler(x, s);
        if (x == 0) begin
          if (s < 10) md[x][2*s +: 2] = cv[1:0];
          else fl[x][1:0] = cv[1:0];
        end else begin
          if (s == 0) fr[x] = cv;
          else if (s < 8) md[x][2*(s-1) +: 2] = cv[1:0];
          else fl[x] = cv;
        end
      end
    end
    q++;
  endtask

  task automatic run(int n);
    repeat (n) step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int x = 0; x < 2; x++) begin
      for (int s = 0; s < 64; s++) lv[x][s] = 1'b0;
      last_code[x] = 0;
    end
    run(3);
    for (int x = 0; x < 2; x++) begin
      chk("R11 out_code", int'(oc[x]), 0);
      chk("R11 out_valid", int'(ov[x]), 0);
      chk("R11 code_error", int'(oe[x]), 0);
    end
    rst_n = 1'b1;
    run(2);
  endtask

  task automatic t_extremes();
    for (int x = 0; x < 2; x++) begin
      logic [32:0] lo, hi;
      lo = '0;
      hi = '0;
      for (int s = 0; s < last_of(x); s++) hi[3*s +: 3] = 3'd2;
      if (x != 0) hi[2:0] = 3'd6;
      hi[3*last_of(x) +: 3] = (x != 0) ? 3'd7 : 3'd3;
      launch(x, q, lo, 0, 0, "R6 all minimum");
      launch(x, q + 1, hi, 4095, 0, "R6 all maximum");
      launch(x, q + 2, zero_pk(x), (x != 0) ? 2044 : 2046, 0, "R1/R2 all zero digits");
    end
    run(16);
  endtask

  task automatic t_weights();
    for (int x = 0; x < 2; x++) begin
      for (int s = 0; s <= last_of(x); s++) begin
        logic [32:0] pk;
        pk = zero_pk(x);
        if (s == last_of(x)) pk[3*s +: 3] = (x != 0) ? 3'd5 : 3'd2;
        else if (x != 0 && s == 0) pk[2:0] = 3'd6;
        else pk[3*s +: 3] = (s % 2 == 0) ? 3'd2 : 3'd0;
        launch(x, q + s, pk, -1, 0, (x != 0) ? "R2/R3 stage weight" : "R1/R3 stage weight");
      end
    end
    run(26);
  endtask

  task automatic t_gaps();
    int offs [5] = '{0, 3, 4, 9, 10};
    for (int x = 0; x < 2; x++)
      for (int i = 0; i < 5; i++) launch(x, q + offs[i], rand_pk(x), -1, 0, "R4/R5 spaced samples");
    run(26);
    for (int x = 0; x < 2; x++)
      for (int i = 0; i < 12; i++) launch(x, q + i, rand_pk(x), -1, 0, "R4 back to back");
    run(28);
  endtask

  task automatic t_analog();
    int vl [10] = '{-VR, VR - 1, 0, VR / 3, -VR / 3, VR / 4, -VR / 4 + 1, (VR / 8) * 5, -(VR / 8) * 3 - 7, 12345};
    for (int x = 0; x < 2; x++) begin
      for (int i = 0; i < 10; i++) launch(x, q + i, model(x, vl[i]), ideal(vl[i]), 1, "R7 offset tolerance");
      for (int i = 10; i < 40; i++) begin
        int v;
        v = int'($urandom % (2 * VR)) - VR;
        launch(x, q + i, model(x, v), ideal(v), 1, "R7 offset tolerance");
      end
    end
    run(54);
  endtask

  task automatic t_ignored();
    for (int m = 1; m <= 2; m++) begin
      junk_mode = m;
      for (int x = 0; x < 2; x++)
        for (int i = 0; i < 6; i++) launch(x, q + i, rand_pk(x), -1, 0, "R10 unused inputs");
      run(20);
    end
    junk_mode = 0;
  endtask

  task automatic t_idle_illegal();
    ill_fill = 1'b1;
    for (int x = 0; x < 2; x++)
      for (int i = 0; i < 8; i++) launch(x, q + 2 + 4*i, rand_pk(x), -1, 0, "R9 values beside idle junk");
    run(50);
    ill_fill = 1'b0;
    run(14);
    for (int x = 0; x < 2; x++) chk("R9 no error from idle cycles", int'(oe[x]), 0);
  endtask

  task automatic t_illegal();
    for (int k = 0; k < 3; k++) begin
      int x;
      logic [32:0] pk;
      t_reset();
      x = (k == 0) ? 0 : 1;
      pk = rand_pk(x);
      if (k == 0) pk[3*4 +: 3] = 3'b011;
      else if (k == 1) pk[2:0] = 3'b111;
      else pk[3*3 +: 3] = 3'b011;
      launch(x, q, pk, -1, 0, "R8 illegal digit counts as zero");
      run(last_of(x) + 1);
      chk("R8 error before sample", int'(oe[x]), 0);
      run(1);
      chk("R8 error with sample", int'(oe[x]), 1);
      chk("R8 error other instance", int'(oe[1 - x]), 0);
      launch(x, q, rand_pk(x), -1, 0, "R8 legal after illegal");
      run(last_of(x) + 4);
      chk("R8 error sticky", int'(oe[x]), 1);
    end
    t_reset();
  endtask

  initial begin
    stb = '{0, 0};
    fr = '{0, 0};
    md = '{0, 0};
    fl = '{0, 0};
    last_code = '{0, 0};
    t_reset();
    t_extremes();
    t_weights();
    t_gaps();
    t_analog();
    t_ignored();
    t_idle_illegal();
    t_illegal();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule